// File: doc/BRIEF.md
# Byte Execution Unit with Status Flags

This block is the data-path core of a small 8-bit processor: a register file of 32 byte-wide registers, an arithmetic and logic stage, and an 8-bit status byte. Each accepted operation carries an opcode, a destination index, a source index and an 8-bit constant. In the same clock edge that accepts it, the unit writes the destination register and, for arithmetic and logic work, updates the flags. Fetch, decode, branching and memory sit outside this block. They drive it through a valid/ready operation channel.

The operation channel follows valid/ready rules. A transfer happens on a rising edge where `op_valid` and `op_ready` are both high. The unit finishes every operation in one cycle, so it never applies back-pressure and `op_ready` is high whenever reset is low. An upstream stage may hold `op_valid` low for any number of cycles. Operation fields are only looked at during a transfer. A combinational peek port and the status output let a debugger or testbench observe state.

Top module: `alu8_exec`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers and the whole status byte to zero.
- R2: Load-constant (opcode 0) with a destination index of 16 or more writes `op_imm` into that register and leaves the status byte unchanged.
- R3: Load-constant (opcode 0) with a destination index of 0 to 15 changes no register and no flag.
- R4: Copy (opcode 1) writes the source register's value into the destination register and leaves the status byte unchanged.
- R5: Add (opcode 2) writes (Rd + Rs) mod 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when both operands share a sign that the result does not (19 + 95 gives 114 with C = 0 and Z = 0).
- R6: Subtract (opcode 3) writes (Rd − Rs) mod 256. C is set when Rd < Rs unsigned, H is set when the low nibble of Rd is below the low nibble of Rs, and V is set when the operand signs differ and the result sign differs from Rd.
- R7: Increment (opcode 4) and decrement (opcode 5) write Rd ± 1 mod 256. V is set only for 0x7F→0x80 (increment) or 0x80→0x7F (decrement). C and H keep their previous values.
- R8: Bitwise AND (opcode 6) writes Rd & Rs, clears V and keeps C and H.
- R9: Status bit positions are 7 I, 6 T, 5 H, 4 S, 3 V, 2 N, 1 Z, 0 C. Every flag-updating operation sets Z when the result is zero and N to result bit 7, and S always equals N XOR V. I and T are only held and stay at their reset value.
- R10: `op_ready` is high outside reset. A cycle with `op_valid` low, or a transfer with opcode 7, changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Unit can take an operation |
| op_code | input | 3 | Operation select |
| op_dst | input | 5 | Destination (and first operand) register index |
| op_src | input | 5 | Second operand register index |
| op_imm | input | 8 | Constant for load-constant |
| peek_addr | input | 5 | Register index to observe |
| peek_data | output | 8 | Contents of register `peek_addr` |
| status | output | 8 | Status byte |

## Verification
The hardest state to reach is an increment or decrement whose C and H are left over from an earlier add or subtract with those flags set. Another is a signed overflow on the 0x7F/0x80 boundary, which random operands rarely hit. Directed sequences therefore load 0x7F and 0x80 and run a carrying add just before the increment, decrement and AND steps. A long random stream over a few destination registers then mixes all opcodes, including low-half load-constant and the reserved opcode. An independent bench model tracks every register and flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;

  typedef enum logic [2:0] {
    OPC_LOADK = 3'd0,
    OPC_COPY  = 3'd1,
    OPC_ADD   = 3'd2,
    OPC_SUB   = 3'd3,
    OPC_INC   = 3'd4,
    OPC_DEC   = 3'd5,
    OPC_AND   = 3'd6,
    OPC_NONE  = 3'd7
  } opc_e;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/alu8_regfile.sv
module alu8_regfile #(
  parameter int DATA_W = 8,
  parameter int NREGS  = 32,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic [AW-1:0]     rc_addr,
  output logic [DATA_W-1:0] rc_data
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else if (we && (waddr == AW'(g))) regs_q[g] <= wdata;
    end
  end

  assign ra_data = regs_q[ra_addr];
  assign rb_data = regs_q[rb_addr];
  assign rc_data = regs_q[rc_addr];

  // R1: after reset the first read port sees zero
  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> (ra_data == '0));
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int HB    = DATA_W / 2,
  localparam int MSB   = DATA_W - 1
) (
  input  opc_e              opc,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] result,
  output arith_flags_t      flags,
  output logic              upd_znvs,
  output logic              upd_ch
);
  logic [DATA_W:0] add_w, sub_w;
  logic [HB:0]     add_lo;
  logic            v_raw;

  assign add_w  = {1'b0, a} + {1'b0, b};
  assign sub_w  = {1'b0, a} - {1'b0, b};
  assign add_lo = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]};

  always_comb begin
    result   = a;
    upd_znvs = 1'b0;
    upd_ch   = 1'b0;
    v_raw    = 1'b0;
    flags    = '0;
    case (opc)
      OPC_LOADK: result = imm;
      OPC_COPY:  result = b;
      OPC_ADD: begin
        result   = add_w[DATA_W-1:0];
        flags.c  = add_w[DATA_W];
        flags.h  = add_lo[HB];
        v_raw    = (a[MSB] == b[MSB]) && (add_w[MSB] != a[MSB]);
        upd_znvs = 1'b1;
        upd_ch   = 1'b1;
      end
      OPC_SUB: begin
        result   = sub_w[DATA_W-1:0];
        flags.c  = sub_w[DATA_W];
        flags.h  = (a[HB-1:0] < b[HB-1:0]);
        v_raw    = (a[MSB] != b[MSB]) && (sub_w[MSB] != a[MSB]);
        upd_znvs = 1'b1;
        upd_ch   = 1'b1;
      end
      OPC_INC: begin
        result   = a + 1'b1;
        v_raw    = (a == {1'b0, {(DATA_W-1){1'b1}}});
        upd_znvs = 1'b1;
      end
      OPC_DEC: begin
        result   = a - 1'b1;
        v_raw    = (a == {1'b1, {(DATA_W-1){1'b0}}});
        upd_znvs = 1'b1;
      end
      OPC_AND: begin
        result   = a & b;
        upd_znvs = 1'b1;
      end
      default: result = a;
    endcase
    flags.v = v_raw;
    flags.n = result[MSB];
    flags.z = (result == '0);
    flags.s = result[MSB] ^ v_raw;
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_znvs,
  input  logic              upd_ch,
  input  arith_flags_t      flags,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      if (upd_znvs) begin
        q[FLAG_S] <= flags.s;
        q[FLAG_V] <= flags.v;
        q[FLAG_N] <= flags.n;
        q[FLAG_Z] <= flags.z;
      end
      if (upd_ch) begin
        q[FLAG_H] <= flags.h;
        q[FLAG_C] <= flags.c;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (q == '0));
  assert_sign_rule_R9: assert property (@(posedge clk) disable iff (rst)
    q[FLAG_S] == (q[FLAG_N] ^ q[FLAG_V]));
  assert_it_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(q[FLAG_I:FLAG_T]));
endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREGS  = 32,
  localparam int AW    = $clog2(NREGS),
  localparam int LOADK_MIN = NREGS / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [AW-1:0]     op_dst,
  input  logic [AW-1:0]     op_src,
  input  logic [DATA_W-1:0] op_imm,
  input  logic [AW-1:0]     peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic [DATA_W-1:0] status
);
  opc_e              opc;
  logic              fire, wr_en, upd_znvs, upd_ch;
  logic [DATA_W-1:0] dst_val, src_val, result;
  arith_flags_t      flags;

  assign opc      = opc_e'(op_code);
  assign op_ready = !rst;
  assign fire     = op_valid && op_ready;

  always_comb begin
    case (opc)
      OPC_LOADK: wr_en = fire && (int'(op_dst) >= LOADK_MIN);
      OPC_NONE:  wr_en = 1'b0;
      default:   wr_en = fire;
    endcase
  end

  alu8_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) rf_i (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(op_dst), .wdata(result),
    .ra_addr(op_dst), .ra_data(dst_val),
    .rb_addr(op_src), .rb_data(src_val),
    .rc_addr(peek_addr), .rc_data(peek_data)
  );

  alu8_arith #(.DATA_W(DATA_W)) arith_i (
    .opc(opc), .a(dst_val), .b(src_val), .imm(op_imm),
    .result(result), .flags(flags), .upd_znvs(upd_znvs), .upd_ch(upd_ch)
  );

  alu8_status #(.DATA_W(DATA_W)) st_i (
    .clk(clk), .rst(rst), .upd_znvs(upd_znvs && fire),
    .upd_ch(upd_ch && fire), .flags(flags), .q(status)
  );

  assert_no_flag_change_R4: assert property (@(posedge clk) disable iff (rst)
    (!fire || opc == OPC_LOADK || opc == OPC_COPY || opc == OPC_NONE) |=> $stable(status));
  assert_ch_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && (opc == OPC_INC || opc == OPC_DEC || opc == OPC_AND))
    |=> $stable({status[FLAG_H], status[FLAG_C]}));
  assert_and_clears_v_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && opc == OPC_AND) |=> !status[FLAG_V]);
  assert_inc_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && opc == OPC_INC && dst_val == {1'b0, {(DATA_W-1){1'b1}}}) |=> status[FLAG_V]);
  assert_low_loadk_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && opc == OPC_LOADK && int'(op_dst) < LOADK_MIN && peek_addr == op_dst)
    ##1 $stable(peek_addr) |-> $stable(peek_data));
endmodule

// File: tb/alu8_exec_tb_top.sv
`timescale 1ns/1ps
module alu8_exec_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic       op_ready;
  logic [2:0] op_code;
  logic [4:0] op_dst, op_src, peek_addr;
  logic [7:0] op_imm, peek_data, status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] exp_rf [32];
  logic [7:0] exp_st;

  always #2.5 clk = ~clk;

  alu8_exec dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_dst(op_dst), .op_src(op_src), .op_imm(op_imm),
    .peek_addr(peek_addr), .peek_data(peek_data), .status(status)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] opc, input logic [4:0] d);
    case (opc)
      3'd0: return (d >= 5'd16) ? "R2" : "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [2:0] opc, input logic [4:0] d, input logic [4:0] s, input logic [7:0] k);
    logic [7:0] a, b, r;
    logic c, h, v;
    bit zn, ch;
    a = exp_rf[d]; b = exp_rf[s]; r = a; c = 0; h = 0; v = 0; zn = 0; ch = 0;
    case (opc)
      3'd0: if (d >= 5'd16) exp_rf[d] = k;
      3'd1: exp_rf[d] = b;
      3'd2: begin r = a + b; c = (int'(a) + int'(b)) > 255; h = (int'(a[3:0]) + int'(b[3:0])) > 15;
                  v = (a[7] == b[7]) && (r[7] != a[7]); zn = 1; ch = 1; end
      3'd3: begin r = a - b; c = a < b; h = a[3:0] < b[3:0];
                  v = (a[7] != b[7]) && (r[7] != a[7]); zn = 1; ch = 1; end
      3'd4: begin r = a + 8'd1; v = (a == 8'h7F); zn = 1; end
      3'd5: begin r = a - 8'd1; v = (a == 8'h80); zn = 1; end
      3'd6: begin r = a & b; v = 0; zn = 1; end
      default: ;
    endcase
    if (zn) begin
      exp_rf[d] = r;
      exp_st[3] = v; exp_st[2] = r[7]; exp_st[1] = (r == 8'h00); exp_st[4] = r[7] ^ v;
    end
    if (ch) begin exp_st[5] = h; exp_st[0] = c; end
  endtask

  task automatic issue(input bit valid, input logic [2:0] opc, input logic [4:0] d,
                       input logic [4:0] s, input logic [7:0] k);
    string tag;
    @(negedge clk);
    op_valid = valid; op_code = opc; op_dst = d; op_src = s; op_imm = k;
    if (valid) model(opc, d, s, k);
    tag = valid ? req_of(opc, d) : "R10";
    @(negedge clk);
    op_valid = 1'b0; op_code = $urandom_range(0, 7); op_dst = $urandom_range(0, 31);
    peek_addr = d;
    #1;
    check(status == exp_st, tag, status, exp_st);
    check(peek_data == exp_rf[d], tag, peek_data, exp_rf[d]);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i++) begin
      peek_addr = 5'(i);
      #0.2;
      check(peek_data == exp_rf[i], tag, peek_data, exp_rf[i]);
    end
    check(status == exp_st, tag, status, exp_st);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=00 expected=01");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; op_valid = 0; op_code = 0; op_dst = 0; op_src = 0; op_imm = 0; peek_addr = 0;
    for (int i = 0; i < 32; i++) exp_rf[i] = 8'h00;
    exp_st = 8'h00;
    // dirty the state, then reset again to prove R1 clears it
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(op_ready == 1'b1, "R10", {7'd0, op_ready}, 8'h01);
    op_valid = 1; op_code = 3'd0; op_dst = 5'd20; op_imm = 8'hA5;
    @(negedge clk);
    op_valid = 1; op_code = 3'd3; op_dst = 5'd20; op_src = 5'd0;
    @(negedge clk);
    op_valid = 0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    sweep("R1");

    // R5 directed: 19 + 95
    issue(1, 3'd0, 5'd16, 5'd0, 8'd19);
    issue(1, 3'd0, 5'd20, 5'd0, 8'd95);
    issue(1, 3'd2, 5'd16, 5'd20, 8'd0);
    check(peek_data == 8'd114 && status[0] == 0 && status[1] == 0, "R5", peek_data, 8'd114);
    // R3: low-half load ignored
    issue(1, 3'd0, 5'd3, 5'd0, 8'hEE);
    check(peek_data == 8'h00, "R3", peek_data, 8'h00);
    issue(1, 3'd1, 5'd3, 5'd16, 8'd0);          // R4 copy into low half
    // carrying add sets C and H, then INC/DEC/AND keep them (R7, R8)
    issue(1, 3'd0, 5'd17, 5'd0, 8'hFF);
    issue(1, 3'd0, 5'd18, 5'd0, 8'h01);
    issue(1, 3'd2, 5'd17, 5'd18, 8'd0);         // 0x00, C=1 H=1 Z=1
    check(status == 8'h23, "R5", status, 8'h23);
    issue(1, 3'd0, 5'd21, 5'd0, 8'h7F);
    issue(1, 3'd4, 5'd21, 5'd0, 8'd0);          // 0x7F -> 0x80, V=1
    check(status[3] == 1'b1 && status[0] == 1'b1, "R7", status, exp_st);
    issue(1, 3'd5, 5'd21, 5'd0, 8'd0);          // 0x80 -> 0x7F, V=1
    issue(1, 3'd6, 5'd21, 5'd18, 8'd0);         // AND, V cleared
    issue(1, 3'd0, 5'd22, 5'd0, 8'h80);
    issue(1, 3'd3, 5'd22, 5'd18, 8'd0);         // R6 0x80-1 overflow
    issue(1, 3'd3, 5'd18, 5'd17, 8'd0);         // R6 1-0 ; then borrow case
    issue(1, 3'd3, 5'd17, 5'd18, 8'd0);         // R6 0-1 borrow, H
    issue(0, 3'd0, 5'd23, 5'd0, 8'h55);         // R10 valid low
    issue(1, 3'd7, 5'd22, 5'd18, 8'h55);        // R10 reserved opcode

    for (int n = 0; n < 2000; n++) begin
      logic [2:0] opc;
      logic [4:0] d;
      opc = 3'($urandom_range(0, 7));
      d = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 15)) : 5'($urandom_range(16, 23));
      issue($urandom_range(0, 9) != 0, opc, d, 5'($urandom_range(0, 31)), 8'($urandom));
    end
    sweep("R9");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule